// File: doc/BRIEF.md
# Per-Channel Clip Indicator Stretcher

This block watches a two-channel stream of signed audio samples for values close to full scale. It has one shared sample strobe and two programmable signed thresholds, one positive and one negative. A sample is a clip event when it lies strictly above the positive threshold or strictly below the negative one. When a channel sees a clip event, that channel's indicator goes high in the same clock cycle as the strobe.

The indicator then stays high for a fixed number of sample periods, set by a parameter that defaults to 4096. It drops by itself once that time has passed. The hold time is counted in strobes, not in clock cycles, so it tracks the sample rate wherever the block sits in the clock tree. A new clip event on a channel whose indicator is already lit starts the count again. Each channel has its own comparator, counter and indicator.

A typical use is a front-panel or status indicator for each channel, driven straight from the converter's output sample stream.

Top module: `clip_flag_stretcher`

## Requirements
- R1: The left and right channels are independent: a clip event on one channel never raises or extends the indicator of the other.
- R2: A strobed sample strictly greater than `thr_pos` is a clip event; a sample equal to `thr_pos` is not.
- R3: A strobed sample strictly less than `thr_neg` is a clip event; a sample equal to `thr_neg` is not.
- R4: The indicator is high combinationally in the same clock cycle as the strobe that carries the clip event, with no register in between.
- R5: After a clip event with no further events, the indicator stays high through the next HOLD strobes and is low from the clock cycle after the HOLD-th following strobe.
- R6: The indicator clears by itself when the hold has expired, with no clear input.
- R7: A clip event while the indicator is high reloads the full hold of HOLD strobes.
- R8: The hold count advances only on strobe cycles, so clock cycles without a strobe between samples do not shorten the hold.
- R9: Sample values in cycles without the strobe are ignored and never raise an indicator.
- R10: Synchronous active-high reset clears both indicators and both hold counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample period |
| smp_left | input | W | Left sample, two's complement |
| smp_right | input | W | Right sample, two's complement |
| thr_pos | input | W | Positive detect threshold, signed |
| thr_neg | input | W | Negative detect threshold, signed |
| flag_left | output | 1 | Left clip indicator |
| flag_right | output | 1 | Right clip indicator |

## Verification
On every cycle the assertions check the following. The indicator is high whenever its channel's comparator reports a hit. A hit reloads the counter to HOLD. A strobe without a hit lowers a running count by exactly one. Cycles without a strobe leave the count untouched, and the count never exceeds HOLD. Which sample values count as a clip event, whether the channels stay separate, and how long the indicator lasts in real strobes (with and without idle gaps, and across retriggers and resets) can only be shown by the bench's scenarios. The bench sweeps every sample value against a reference model computed from the requirements.

// File: rtl/clip_pkg.sv
package clip_pkg;

    localparam int NUM_CH = 2;
    localparam int CH_L   = 0;
    localparam int CH_R   = 1;

    typedef struct packed {
        logic hit;   // comparator result in this cycle (strobe qualified)
        logic hold;  // stretch counter still running
    } chan_stat_t;

    function automatic logic stat_flag(chan_stat_t s);
        return s.hit | s.hold;
    endfunction

endpackage

// File: rtl/clip_detect.sv
module clip_detect #(
    parameter int W = 20
) (
    input  logic                vld,
    input  logic signed [W-1:0] sample,
    input  logic signed [W-1:0] lim_hi,
    input  logic signed [W-1:0] lim_lo,
    output logic                hit
);
    logic above;
    logic below;

    always_comb begin
        above = (sample > lim_hi);
        below = (sample < lim_lo);
        hit   = vld & (above | below);
    end

endmodule

// File: rtl/clip_stretch.sv
module clip_stretch #(
    parameter int HOLD = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic vld,
    input  logic hit,
    output logic hold
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (vld) begin
            if (hit)
                cnt_q <= FULL;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - CW'(1);
        end
    end

    assign hold = (cnt_q != '0);

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(cnt_q)); // R8
    AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (rst)
        (vld && hit) |=> (cnt_q == FULL)); // R7
    AST_DECAY_ONE: assert property (@(posedge clk) disable iff (rst)
        (vld && !hit && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R5
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL); // R5

endmodule

// File: rtl/clip_flag_stretcher.sv
module clip_flag_stretcher
    import clip_pkg::*;
#(
    parameter int W    = 20,
    parameter int HOLD = 4096
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_vld,
    input  logic signed [W-1:0] smp_left,
    input  logic signed [W-1:0] smp_right,
    input  logic signed [W-1:0] thr_pos,
    input  logic signed [W-1:0] thr_neg,
    output logic                flag_left,
    output logic                flag_right
);
    logic signed [W-1:0] smp_arr [NUM_CH];
    chan_stat_t          stat    [NUM_CH];
    logic [NUM_CH-1:0]   flag_vec;

    assign smp_arr[CH_L] = smp_left;
    assign smp_arr[CH_R] = smp_right;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic hit_c;
        logic hold_c;

        clip_detect #(.W(W)) u_det (
            .vld    (smp_vld),
            .sample (smp_arr[ch]),
            .lim_hi (thr_pos),
            .lim_lo (thr_neg),
            .hit    (hit_c)
        );

        clip_stretch #(.HOLD(HOLD)) u_str (
            .clk  (clk),
            .rst  (rst),
            .vld  (smp_vld),
            .hit  (hit_c),
            .hold (hold_c)
        );

        assign stat[ch]     = '{hit: hit_c, hold: hold_c};
        assign flag_vec[ch] = stat_flag(stat[ch]);

        AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (rst)
            hit_c |-> flag_vec[ch]); // R4
        AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
            hit_c |-> smp_vld); // R9
    end

    assign flag_left  = flag_vec[CH_L];
    assign flag_right = flag_vec[CH_R];

endmodule

// File: tb/clip_flag_stretcher_test.sv
module clip_flag_stretcher_test;
    localparam int W    = 8;
    localparam int HOLD = 5;
    localparam int POS  = 50;
    localparam int NEG  = -60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_vld = 1'b0;
    logic signed [W-1:0] smp_left = '0;
    logic signed [W-1:0] smp_right = '0;
    logic signed [W-1:0] thr_pos = W'(POS);
    logic signed [W-1:0] thr_neg = W'(NEG);
    logic flag_left, flag_right;

    int errors = 0;
    int checks = 0;
    int m_l = 0;
    int m_r = 0;
    bit done = 0;

    always #5 clk = ~clk;

    clip_flag_stretcher #(.W(W), .HOLD(HOLD)) uut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld),
        .smp_left(smp_left), .smp_right(smp_right),
        .thr_pos(thr_pos), .thr_neg(thr_neg),
        .flag_left(flag_left), .flag_right(flag_right)
    );

    function automatic bit is_clip(int v);
        return (v > POS) || (v < NEG);
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One strobe; flags checked during the strobe cycle, model updated at the edge.
    task automatic strobe(int l, int r, string tag);
        bit hl, hr;
        @(negedge clk);
        smp_vld = 1'b1;
        smp_left = W'(l);
        smp_right = W'(r);
        hl = is_clip(l);
        hr = is_clip(r);
        #2;
        chk({tag, " left"},  flag_left,  (m_l > 0) || hl);
        chk({tag, " right"}, flag_right, (m_r > 0) || hr);
        @(posedge clk);
        if (hl) m_l = HOLD; else if (m_l > 0) m_l--;
        if (hr) m_r = HOLD; else if (m_r > 0) m_r--;
        #1 smp_vld = 1'b0;
    endtask

    // Idle cycles; any sample value present is driven without the strobe.
    task automatic idle(int n, int l, int r, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_left = W'(l);
            smp_right = W'(r);
            #2;
            chk({tag, " left"},  flag_left,  m_l > 0);
            chk({tag, " right"}, flag_right, m_r > 0);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < HOLD; i++) strobe(0, 0, "R6 drain");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        idle(1, 0, 0, "R10 reset state");

        // R2 R3 R5 R8 R1: sweep every left value, right quiet, with idle gaps
        for (int v = -128; v < 128; v++) begin
            strobe(v, 0, "R1 R2 R3 R5 sweep-left");
            idle((v + 128) % 3, 0, 0, "R8 gap");
        end
        drain();
        // same sweep on the right channel
        for (int v = -128; v < 128; v++) begin
            strobe(0, v, "R1 R2 R3 R5 sweep-right");
            idle((v + 128) % 2, 0, 0, "R8 gap");
        end
        drain();

        // R2 boundary: equal is not a clip, one above is
        strobe(POS, 0, "R2 equal-pos");
        strobe(POS + 1, 0, "R2 above-pos");
        drain();
        // R3 boundary
        strobe(0, NEG, "R3 equal-neg");
        strobe(0, NEG - 1, "R3 below-neg");
        drain();

        // R5 R6 exact length with long idle gaps (R8)
        strobe(127, 0, "R4 hit");
        for (int i = 0; i < HOLD; i++) begin
            idle(7, 0, 0, "R8 long gap");
            strobe(0, 0, "R5 hold");
        end
        idle(2, 0, 0, "R6 cleared");
        chk("R6 left low after hold", flag_left, 1'b0);

        // R7 retrigger
        strobe(-128, 0, "R7 first hit");
        for (int i = 0; i < 3; i++) strobe(0, 0, "R7 running");
        strobe(100, 0, "R7 retrigger");
        for (int i = 0; i < HOLD; i++) strobe(0, 0, "R7 reloaded");
        chk("R7 left low after reload", flag_left, 1'b0);

        // R9 samples without strobe ignored
        idle(6, 127, -128, "R9 no strobe");
        chk("R9 left", flag_left, 1'b0);
        chk("R9 right", flag_right, 1'b0);

        // R10 reset mid-hold
        strobe(127, -128, "R10 arm");
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        m_l = 0;
        m_r = 0;
        idle(1, 0, 0, "R10 after reset");
        strobe(0, 0, "R10 counters cleared");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule